// File: doc/BRIEF.md
# Mouse Cursor Position Accumulator

This block turns a stream of relative pointer motion packets into an absolute cursor position on a 640 by 480 screen. Received bytes arrive one at a time, each marked by a valid strobe. Every three accepted bytes form one packet: a status byte carrying the button states and an alignment marker, a signed horizontal motion byte and a signed vertical motion byte.

When a packet completes, the block sign-extends both motion bytes, adds them to its column and row registers and clamps each result to the visible area. In the same edge it registers the two button states and raises a one-cycle strobe. A status byte without its marker bit is dropped, so the block regains packet alignment after a lost or extra byte.

Top module: `cursor_tracker`

## Requirements
- R1: After reset the column output is 320, the row output is 240, both button outputs are 0 and the update strobe is 0.
- R2: Column, row and button outputs change only on the cycle the update strobe is high; the first two bytes of a packet change none of them.
- R3: The second packet byte, read as an 8-bit two's complement number, is added to the column.
- R4: The third packet byte, read as an 8-bit two's complement number, is added to the row.
- R5: The column is clamped to 0..639; motion past either edge leaves it at that edge.
- R6: The row is clamped to 0..479; motion past either edge leaves it at that edge.
- R7: The left button output takes bit 0 and the right button output bit 1 of the first packet byte, both loaded on the update cycle.
- R8: A byte in the first packet position with bit 3 clear is discarded and the next byte is again treated as a first byte.
- R9: The update strobe is high for exactly one cycle, the first cycle in which the new position and buttons are visible, one clock after the third byte is sampled.
- R10: Cycles with the valid strobe low are ignored whatever the data input holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | rx_byte holds a new byte this cycle |
| cursor_col | output | 10 | Cursor column, 0..639 |
| cursor_row | output | 10 | Cursor row, 0..479 |
| btn_left | output | 1 | Left button state |
| btn_right | output | 1 | Right button state |
| upd | output | 1 | One-cycle strobe: new position and buttons valid |

## Verification
The assertions take for granted that a valid strobe lasts one cycle per byte and that reset is held for at least one clock edge, so every register has a defined value before any property is checked. The stimulus drives each byte for a single cycle on the falling edge, inserts idle cycles carrying junk data with the strobe low, and sends unmarked status bytes only where the bench model expects them to be dropped. Motion values run to both 8-bit extremes so that the clamps are reached from inside the screen on all four edges.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int POS_W   = 10;
  localparam int DELTA_W = 8;
  localparam int ACC_W   = POS_W + 2;
  localparam int BYTE_W  = 8;

  // two's complement widening of one motion byte
  function automatic logic signed [ACC_W-1:0] widen_delta(input logic [DELTA_W-1:0] d);
    return {{(ACC_W-DELTA_W){d[DELTA_W-1]}}, d};
  endfunction
endpackage

// File: rtl/pkt_framer.sv
module pkt_framer
  import cursor_pkg::*;
#(
  parameter int PKT_LEN  = 3,
  parameter int SYNC_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  output logic              pkt_fire,
  output logic [BYTE_W-1:0] status_byte,
  output logic [BYTE_W-1:0] dx_byte,
  output logic [BYTE_W-1:0] dy_byte
);
  localparam int CNT_W = $clog2(PKT_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_LEN - 1);

  logic [CNT_W-1:0]  slot;
  logic [BYTE_W-1:0] hold_status;
  logic [BYTE_W-1:0] hold_dx;
  logic              first_ok;
  logic              drop_byte;
  logic              take_byte;

  assign first_ok  = rx_byte[SYNC_BIT];
  assign drop_byte = rx_valid && (slot == '0) && !first_ok;
  assign take_byte = rx_valid && !drop_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot        <= '0;
      hold_status <= '0;
      hold_dx     <= '0;
    end else if (take_byte) begin
      if (slot == '0) hold_status <= rx_byte;
      if (slot == CNT_W'(1)) hold_dx <= rx_byte;
      slot <= (slot == LAST) ? '0 : slot + CNT_W'(1);
    end
  end

  assign pkt_fire    = take_byte && (slot == LAST);
  assign status_byte = hold_status;
  assign dx_byte     = hold_dx;
  assign dy_byte     = rx_byte;

  // R8: slot never leaves the packet range
  p_slot_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= LAST);
  // R8: an unmarked first byte keeps the framer at slot 0
  p_resync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_byte |=> (slot == '0));
  // R10: idle cycles do not advance the framer
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(slot));
endmodule

// File: rtl/pos_axis.sv
module pos_axis
  import cursor_pkg::*;
#(
  parameter int RESET_POS = 320,
  parameter int LIMIT     = 640
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DELTA_W-1:0] delta,
  output logic [POS_W-1:0]   pos
);
  localparam logic signed [ACC_W-1:0] HI = ACC_W'(LIMIT - 1);
  localparam logic [POS_W-1:0] TOP = POS_W'(LIMIT - 1);
  localparam logic [POS_W-1:0] START = POS_W'(RESET_POS);

  // add a signed step and hold the result inside 0..LIMIT-1
  function automatic logic [POS_W-1:0] step_clamp(input logic [POS_W-1:0] p,
                                                  input logic [DELTA_W-1:0] d);
    logic signed [ACC_W-1:0] s;
    s = $signed({2'b00, p}) + widen_delta(d);
    if (s < 0) return '0;
    else if (s > HI) return TOP;
    else return s[POS_W-1:0];
  endfunction

  logic [POS_W-1:0] next_pos;
  assign next_pos = step_clamp(pos, delta);

  always_ff @(posedge clk) begin
    if (!rst_n) pos <= START;
    else if (load) pos <= next_pos;
  end

  // R5 (column instance) and R6 (row instance): never outside the screen
  p_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= TOP);
  // R2: no packet, no move
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(pos));
endmodule

// File: rtl/cursor_tracker.sv
module cursor_tracker
  import cursor_pkg::*;
#(
  parameter int SCREEN_W = 640,
  parameter int SCREEN_H = 480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  output logic [POS_W-1:0]  cursor_col,
  output logic [POS_W-1:0]  cursor_row,
  output logic              btn_left,
  output logic              btn_right,
  output logic              upd
);
  localparam int START_COL = SCREEN_W / 2;
  localparam int START_ROW = SCREEN_H / 2;

  logic              pkt_fire;
  logic [BYTE_W-1:0] status_byte;
  logic [BYTE_W-1:0] dx_byte;
  logic [BYTE_W-1:0] dy_byte;

  pkt_framer #(.PKT_LEN(3), .SYNC_BIT(3)) u_framer (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .pkt_fire(pkt_fire), .status_byte(status_byte),
    .dx_byte(dx_byte), .dy_byte(dy_byte)
  );

  pos_axis #(.RESET_POS(START_COL), .LIMIT(SCREEN_W)) u_col (
    .clk(clk), .rst_n(rst_n), .load(pkt_fire), .delta(dx_byte), .pos(cursor_col)
  );

  pos_axis #(.RESET_POS(START_ROW), .LIMIT(SCREEN_H)) u_row (
    .clk(clk), .rst_n(rst_n), .load(pkt_fire), .delta(dy_byte), .pos(cursor_row)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      btn_left  <= 1'b0;
      btn_right <= 1'b0;
      upd       <= 1'b0;
    end else begin
      upd <= pkt_fire;
      if (pkt_fire) begin
        btn_left  <= status_byte[0];
        btn_right <= status_byte[1];
      end
    end
  end

  // R9: strobe never lasts two cycles
  p_upd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);
  // R7: buttons move only with the strobe
  p_btn_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |-> $stable({btn_left, btn_right}));
  // R2: position outputs move only with the strobe
  p_pos_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |-> $stable({cursor_col, cursor_row}));
endmodule

// File: tb/cursor_tracker_tb.sv
module cursor_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_valid = 1'b0;
  logic [9:0] cursor_col, cursor_row;
  logic       btn_left, btn_right, upd;

  typedef struct { int col; int row; bit l; bit r; string tag; } exp_t;
  exp_t q[$];

  int n_checks = 0;
  int n_fail = 0;
  int m_col = 320, m_row = 240;
  bit m_l = 0, m_r = 0;
  bit mon_on = 0;
  bit prev_upd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cursor_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .cursor_col(cursor_col), .cursor_row(cursor_row),
    .btn_left(btn_left), .btn_right(btn_right), .upd(upd)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int as_signed(input logic [7:0] b);
    return (b > 127) ? int'(b) - 256 : int'(b);
  endfunction

  function automatic int bound(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic put(input logic [7:0] b, input int idle);
    @(negedge clk);
    rx_byte  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_byte  = 8'hF7;
    repeat (idle) @(negedge clk);
  endtask

  // driver: updates the model and queues the expected result
  task automatic send_pkt(input logic [7:0] st, input logic [7:0] dx, input logic [7:0] dy,
                          input int idle, input string tag);
    exp_t e;
    m_col = bound(m_col + as_signed(dx), 639);
    m_row = bound(m_row + as_signed(dy), 479);
    m_l = st[0];
    m_r = st[1];
    e.col = m_col; e.row = m_row; e.l = m_l; e.r = m_r; e.tag = tag;
    q.push_back(e);
    put(st, idle);
    put(dx, idle);
    put(dy, idle);
  endtask

  // monitor: compare on strobe, check holding otherwise
  always @(negedge clk) begin
    if (mon_on) begin
      check(!(upd && prev_upd), "R9 strobe width", int'(upd), 0);
      if (upd) begin
        if (q.size() == 0) begin
          check(1'b0, "R2 unexpected update", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(int'(cursor_col) == e.col, {e.tag, " col"}, int'(cursor_col), e.col);
          check(int'(cursor_row) == e.row, {e.tag, " row"}, int'(cursor_row), e.row);
          check(btn_left == e.l, {"R7 left ", e.tag}, int'(btn_left), int'(e.l));
          check(btn_right == e.r, {"R7 right ", e.tag}, int'(btn_right), int'(e.r));
        end
      end else if (q.size() == 0) begin
        // between packets the outputs must match the last model state (R2, R10)
        check(int'(cursor_col) == m_col && int'(cursor_row) == m_row,
              "R2 R10 hold", int'(cursor_col) * 1000 + int'(cursor_row), m_col * 1000 + m_row);
      end
      prev_upd = upd;
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(cursor_col == 10'd320, "R1 col", int'(cursor_col), 320);
    check(cursor_row == 10'd240, "R1 row", int'(cursor_row), 240);
    check(!btn_left && !btn_right, "R1 buttons", int'({btn_left, btn_right}), 0);
    check(!upd, "R1 strobe", int'(upd), 0);
    mon_on = 1;

    // R3 R4 R7: positive motion, left button
    send_pkt(8'h09, 8'd10, 8'd5, 0, "R3 R4 plus");
    // R2: partial packet moves nothing, then finish it
    put(8'h0A, 0);
    put(8'hF6, 2);
    check(cursor_col == 10'd330 && !upd, "R2 partial", int'(cursor_col), 330);
    begin
      exp_t e;
      m_col = bound(m_col - 10, 639);
      m_row = bound(m_row - 128, 479);
      m_l = 0; m_r = 1;
      e.col = m_col; e.row = m_row; e.l = 0; e.r = 1; e.tag = "R3 R4 minus";
      q.push_back(e);
      put(8'h80, 2);
    end

    // R8: unmarked status byte dropped, then a good packet
    put(8'h00, 1);
    put(8'h37, 1);
    send_pkt(8'h0B, 8'd1, 8'd2, 0, "R8 resync");

    // R10: gaps with junk data between bytes
    send_pkt(8'h08, 8'hFF, 8'h01, 3, "R10 gaps");

    // R5 R6: drive to the low edges
    for (int i = 0; i < 4; i++) send_pkt(8'h08, 8'h80, 8'h80, 0, "R5 R6 low");
    check(cursor_col == 10'd0, "R5 low edge", int'(cursor_col), 0);
    check(cursor_row == 10'd0, "R6 low edge", int'(cursor_row), 0);

    // R5 R6: drive to the high edges
    for (int i = 0; i < 7; i++) send_pkt(8'h0B, 8'h7F, 8'h7F, 0, "R5 R6 high");
    check(cursor_col == 10'd639, "R5 high edge", int'(cursor_col), 639);
    check(cursor_row == 10'd479, "R6 high edge", int'(cursor_row), 479);

    // back off from the edges
    send_pkt(8'h08, 8'hFF, 8'hFF, 0, "R3 R4 back off");

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R2 R9 all packets reported", q.size(), 0);
    finish_run();
  end
endmodule